// File: doc/BRIEF.md
# DMA Channel Status and Command Register Bank

This block is the software-visible control and status front of a multi-channel DMA engine. It keeps four per-channel bitmaps: hardware-request enable, error-interrupt enable, interrupt pending and error pending. Each bitmap is read and written as two 32-bit words, one for channels 63..32 and one for channels 31..0. Software can change a single channel's bit without a read-modify-write. It writes the channel number to a command register, and the block sets or clears that one bit. A done bitmap records finished channels, and a control word holds the clock-gating and arbitration-mode bits.

The transfer engine reports completion and failure through per-channel event strobes. Failures carry a 10-bit cause code. The block records the first failure in an error status word, which keeps it until software clears the error on the recorded channel. A write to the start command sends a one-cycle start strobe with the channel index to the engine. A single interrupt line combines pending completions and enabled pending errors. The channel count is a parameter (64 or 16). In the 16-channel build only the low words hold state.

Top module: `dma_chan_status_bank`

## Requirements
- R1: After reset every bitmap, the control word and the error status word read zero, and `irq` and `start_pulse` are low.
- R2: The control word (offset 0x00) keeps only bits 31 (clock-gating enable), 3 (round-robin group arbitration) and 2 (round-robin channel arbitration). All other bits read zero.
- R3: The request-enable words (0x08 high, 0x0C low) and the error-interrupt-enable words (0x10 high, 0x14 low) are written and read back whole. A high word holds channels 63..32, with channel 32 at bit 0.
- R4: The command registers take the channel number from write-data bits 5..0 and ignore the upper bits. Their offsets are: 0x28 set request enable, 0x2C clear request enable, 0x30 set error-interrupt enable, 0x34 clear error-interrupt enable. Each write sets or clears only that channel's bit.
- R5: A done event sets the channel's interrupt-pending bit (0x18 high, 0x1C low) and its done bit (0x48 high, 0x4C low). Clear-interrupt (0x38) and clear-done (0x44) commands clear one bit each. An event in the same cycle as a clear of the same bit leaves the bit set.
- R6: The interrupt-pending and error-pending words (0x20 high, 0x24 low) are write-one-to-clear. Zero bits in the write data leave bits unchanged, and all ones clears every channel in that word.
- R7: An error event sets the channel's error-pending bit.
- R8: `irq` is high exactly when any interrupt-pending bit is set, or any error-pending bit is set together with the same channel's error-interrupt-enable bit.
- R9: The error status word (0x04, read-only) has these fields: valid in bit 31, cause bits 9 and 8 in bits 15 and 14, the channel in bits 13..8, and cause bits 7..0 in bits 7..0. It is loaded on an error event only while valid is clear. With several simultaneous events it records the lowest channel. It keeps the first error while later ones arrive.
- R10: A clear-error command (0x3C) clears that channel's error-pending bit. It clears the error status word only when it names the recorded channel.
- R11: A write to the set-start command (0x40) drives `start_pulse` high for one cycle after the write edge, with `start_chan` equal to the channel number.
- R12: With 16 channels, the high words read zero and ignore writes, and commands naming channels 16..63 have no effect (including no start strobe).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| done_evt | input | NCH | Per-channel completion strobes |
| err_evt | input | NCH | Per-channel error strobes |
| err_cause | input | 10 | Cause code accompanying `err_evt` |
| start_pulse | output | 1 | One-cycle start request to the engine |
| start_chan | output | 6 | Channel index for `start_pulse` |
| irq | output | 1 | Combined interrupt |

## Verification
Commands are driven with channels on both sides of the 32-bit word boundary, and with junk in the upper data bits, to separate high/low word placement and the 6-bit field decode from wider decodes. Errors are injected on two channels at once and then on a third, which distinguishes lowest-channel selection and first-error retention from last-error overwrite. Clear-error is issued for a non-recorded channel before the recorded one. A done event collides with its own clear in one cycle to check event priority. A 16-channel instance on the same bus shows that out-of-range channels and high words are inert.

// File: rtl/dma_chan_status_bank.sv
module dma_chan_status_bank #(
  parameter int NCH = 64,
  parameter int AW  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] done_evt,
  input  logic [NCH-1:0] err_evt,
  input  logic [9:0]     err_cause,
  output logic           start_pulse,
  output logic [5:0]     start_chan,
  output logic           irq
);
  localparam logic [63:0] CH_MASK = (NCH >= 64) ? {64{1'b1}} : ((64'd1 << NCH) - 64'd1);
  localparam logic [31:0] CTRL_MASK = 32'h8000_000C;

  localparam logic [AW-1:0] A_CTRL = AW'('h00);
  localparam logic [AW-1:0] A_EST  = AW'('h04);
  localparam logic [AW-1:0] A_REQH = AW'('h08);
  localparam logic [AW-1:0] A_REQL = AW'('h0C);
  localparam logic [AW-1:0] A_EIEH = AW'('h10);
  localparam logic [AW-1:0] A_EIEL = AW'('h14);
  localparam logic [AW-1:0] A_IPH  = AW'('h18);
  localparam logic [AW-1:0] A_IPL  = AW'('h1C);
  localparam logic [AW-1:0] A_EPH  = AW'('h20);
  localparam logic [AW-1:0] A_EPL  = AW'('h24);
  localparam logic [AW-1:0] A_SREQ = AW'('h28);
  localparam logic [AW-1:0] A_CREQ = AW'('h2C);
  localparam logic [AW-1:0] A_SEIE = AW'('h30);
  localparam logic [AW-1:0] A_CEIE = AW'('h34);
  localparam logic [AW-1:0] A_CINT = AW'('h38);
  localparam logic [AW-1:0] A_CERR = AW'('h3C);
  localparam logic [AW-1:0] A_SST  = AW'('h40);
  localparam logic [AW-1:0] A_CDNE = AW'('h44);
  localparam logic [AW-1:0] A_DNH  = AW'('h48);
  localparam logic [AW-1:0] A_DNL  = AW'('h4C);

  logic [31:0] ctrl;
  logic [63:0] req_en, eie, ipend, epend, done_q;
  logic        err_valid;
  logic [5:0]  err_chan;
  logic [9:0]  err_cause_q;

  logic [63:0] done64, err64;
  always_comb begin
    done64 = '0;
    err64  = '0;
    done64[NCH-1:0] = done_evt;
    err64[NCH-1:0]  = err_evt;
  end

  wire [5:0]  cmd_ch = bus_wdata[5:0];
  wire        cmd_ok = ({26'd0, cmd_ch} < 32'(NCH));
  wire [63:0] hot    = cmd_ok ? (64'd1 << cmd_ch) : 64'd0;
  wire [63:0] wvec   = {bus_wdata, bus_wdata};

  function automatic logic [63:0] wsel(input logic hi, input logic lo);
    return {{32{hi}}, {32{lo}}};
  endfunction

  wire w_ctrl = bus_wr && bus_addr == A_CTRL;
  wire w_sreq = bus_wr && bus_addr == A_SREQ;
  wire w_creq = bus_wr && bus_addr == A_CREQ;
  wire w_seie = bus_wr && bus_addr == A_SEIE;
  wire w_ceie = bus_wr && bus_addr == A_CEIE;
  wire w_cint = bus_wr && bus_addr == A_CINT;
  wire w_cerr = bus_wr && bus_addr == A_CERR;
  wire w_sst  = bus_wr && bus_addr == A_SST;
  wire w_cdne = bus_wr && bus_addr == A_CDNE;

  wire [63:0] sel_req = wsel(bus_wr && bus_addr == A_REQH, bus_wr && bus_addr == A_REQL);
  wire [63:0] sel_eie = wsel(bus_wr && bus_addr == A_EIEH, bus_wr && bus_addr == A_EIEL);
  wire [63:0] sel_ip  = wsel(bus_wr && bus_addr == A_IPH,  bus_wr && bus_addr == A_IPL);
  wire [63:0] sel_ep  = wsel(bus_wr && bus_addr == A_EPH,  bus_wr && bus_addr == A_EPL);

  wire [63:0] req_en_n = (((req_en & ~sel_req) | (wvec & sel_req) | (w_sreq ? hot : '0))
                          & ~(w_creq ? hot : 64'd0)) & CH_MASK;
  wire [63:0] eie_n    = (((eie & ~sel_eie) | (wvec & sel_eie) | (w_seie ? hot : '0))
                          & ~(w_ceie ? hot : 64'd0)) & CH_MASK;
  wire [63:0] ipend_n  = ((ipend & ~(wvec & sel_ip) & ~(w_cint ? hot : 64'd0)) | done64) & CH_MASK;
  wire [63:0] epend_n  = ((epend & ~(wvec & sel_ep) & ~(w_cerr ? hot : 64'd0)) | err64) & CH_MASK;
  wire [63:0] done_n   = ((done_q & ~(w_cdne ? hot : 64'd0)) | done64) & CH_MASK;

  logic [5:0] first_ch;
  always_comb begin
    first_ch = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (err64[i]) first_ch = 6'(i);
  end

  wire any_err = |(err64 & CH_MASK);
  wire clr_hit = w_cerr && err_valid && cmd_ok && (cmd_ch == err_chan);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl        <= '0;
      req_en      <= '0;
      eie         <= '0;
      ipend       <= '0;
      epend       <= '0;
      done_q      <= '0;
      err_valid   <= 1'b0;
      err_chan    <= '0;
      err_cause_q <= '0;
      start_pulse <= 1'b0;
      start_chan  <= '0;
    end else begin
      if (w_ctrl) ctrl <= bus_wdata & CTRL_MASK;
      req_en <= req_en_n;
      eie    <= eie_n;
      ipend  <= ipend_n;
      epend  <= epend_n;
      done_q <= done_n;
      if (clr_hit) begin
        err_valid   <= 1'b0;
        err_chan    <= '0;
        err_cause_q <= '0;
      end else if (!err_valid && any_err) begin
        err_valid   <= 1'b1;
        err_chan    <= first_ch;
        err_cause_q <= err_cause;
      end
      start_pulse <= w_sst && cmd_ok;
      if (w_sst && cmd_ok) start_chan <= cmd_ch;
    end
  end

  wire [31:0] est_word = {err_valid, 15'd0, err_cause_q[9], err_cause_q[8], err_chan, err_cause_q[7:0]};

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_EST:   bus_rdata = est_word;
      A_REQH:  bus_rdata = req_en[63:32];
      A_REQL:  bus_rdata = req_en[31:0];
      A_EIEH:  bus_rdata = eie[63:32];
      A_EIEL:  bus_rdata = eie[31:0];
      A_IPH:   bus_rdata = ipend[63:32];
      A_IPL:   bus_rdata = ipend[31:0];
      A_EPH:   bus_rdata = epend[63:32];
      A_EPL:   bus_rdata = epend[31:0];
      A_DNH:   bus_rdata = done_q[63:32];
      A_DNL:   bus_rdata = done_q[31:0];
      default: bus_rdata = 32'd0;
    endcase
  end

  assign irq = |ipend || |(epend & eie);
endmodule

// File: rtl/dma_chan_status_bank_chk.sv
module dma_chan_status_bank_chk #(
  parameter int NCH = 64,
  parameter int AW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] done_evt,
  input logic [NCH-1:0] err_evt,
  input logic           start_pulse,
  input logic           irq,
  input logic           err_valid,
  input logic [5:0]     err_chan,
  input logic [63:0]    ipend,
  input logic [63:0]    epend
);
  // R11
  start_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(bus_wr && bus_addr == AW'('h40)));

  // R5
  done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_evt) |=> irq);

  // R7
  err_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> (|epend));

  // R9
  first_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $past(err_valid) && !$past(bus_wr && bus_addr == AW'('h3C))) |-> $stable(err_chan));

  // R6
  w1c_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == AW'('h1C) && bus_wdata == 32'hFFFF_FFFF && done_evt == '0)
      |-> ipend[31:0] == 32'd0);

  // R12
  hi_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NCH <= 32 && bus_addr == AW'('h08)) |-> bus_rdata == 32'd0);
endmodule

bind dma_chan_status_bank dma_chan_status_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .done_evt(done_evt), .err_evt(err_evt), .start_pulse(start_pulse),
  .irq(irq), .err_valid(err_valid), .err_chan(err_chan), .ipend(ipend), .epend(epend)
);

// File: tb/tb_dma_chan_status_bank.sv
module tb_dma_chan_status_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] CTRL = 7'h00, EST = 7'h04, REQH = 7'h08, REQL = 7'h0C,
    EIEH = 7'h10, EIEL = 7'h14, IPH = 7'h18, IPL = 7'h1C, EPH = 7'h20, EPL = 7'h24,
    SREQ = 7'h28, CREQ = 7'h2C, SEIE = 7'h30, CEIE = 7'h34, CINT = 7'h38, CERR = 7'h3C,
    SST = 7'h40, CDNE = 7'h44, DNH = 7'h48, DNL = 7'h4C;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [6:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, rdata, rdata16;
  logic [63:0] done_evt = 0, err_evt = 0;
  logic [15:0] done16 = 0, err16 = 0;
  logic [9:0] err_cause = 0;
  logic start_pulse, start16, irq, irq16;
  logic [5:0] start_chan, schan16;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_status_bank #(.NCH(64)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .done_evt(done_evt), .err_evt(err_evt), .err_cause(err_cause),
    .start_pulse(start_pulse), .start_chan(start_chan), .irq(irq));

  dma_chan_status_bank #(.NCH(16)) dut16 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata16), .done_evt(done16), .err_evt(err16), .err_cause(err_cause),
    .start_pulse(start16), .start_chan(schan16), .irq(irq16));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1 v = rdata;
  endtask

  task automatic rchk(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse(input logic [63:0] d, input logic [63:0] e, input logic [9:0] c);
    @(negedge clk); done_evt = d; err_evt = e; err_cause = c;
    @(negedge clk); done_evt = 0; err_evt = 0; err_cause = 0;
  endtask

  task automatic t_reset;
    rchk("R1 ctrl", CTRL, 0);
    rchk("R1 est", EST, 0);
    rchk("R1 reql", REQL, 0);
    rchk("R1 iph", IPH, 0);
    rchk("R1 epl", EPL, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 start", {31'd0, start_pulse}, 0);
  endtask

  task automatic t_ctrl;
    wr(CTRL, 32'hFFFF_FFFF);
    rchk("R2 ctrl mask", CTRL, 32'h8000_000C);
    wr(CTRL, 0);
  endtask

  task automatic t_words;
    wr(REQH, 32'hDEAD_0001);
    wr(REQL, 32'h1234_5678);
    wr(EIEL, 32'h0F0F_0F0F);
    rchk("R3 reqh", REQH, 32'hDEAD_0001);
    rchk("R3 reql", REQL, 32'h1234_5678);
    rchk("R3 eiel", EIEL, 32'h0F0F_0F0F);
    rchk("R3 eieh", EIEH, 0);
  endtask

  task automatic t_cmds;
    wr(CREQ, 32);
    rchk("R4 clr ch32", REQH, 32'hDEAD_0000);
    wr(CREQ, 63);
    rchk("R4 clr ch63", REQH, 32'h5EAD_0000);
    wr(SREQ, 7);
    rchk("R4 set ch7", REQL, 32'h1234_56F8);
    wr(SREQ, 32'hFFFF_FFC1);
    rchk("R4 upper bits ignored", REQL, 32'h1234_56FA);
    wr(CEIE, 0);
    rchk("R4 clr eie ch0", EIEL, 32'h0F0F_0F0E);
    wr(SEIE, 33);
    rchk("R4 set eie ch33", EIEH, 32'h0000_0002);
    wr(REQH, 0); wr(REQL, 0); wr(EIEH, 0); wr(EIEL, 0);
  endtask

  task automatic t_done;
    pulse(64'h8, 0, 0);
    rchk("R5 ipend set", IPL, 32'h8);
    rchk("R5 done set", DNL, 32'h8);
    chk("R8 irq on ipend", {31'd0, irq}, 1);
    wr(CINT, 3);
    rchk("R5 clr int", IPL, 0);
    rchk("R5 done kept", DNL, 32'h8);
    chk("R8 irq low", {31'd0, irq}, 0);
    wr(CDNE, 3);
    rchk("R5 clr done", DNL, 0);
    @(negedge clk); bus_wr = 1; bus_addr = CINT; bus_wdata = 4; done_evt = 64'h10;
    @(negedge clk); bus_wr = 0; done_evt = 0;
    rchk("R5 event beats clear", IPL, 32'h10);
    wr(IPL, 32'hFFFF_FFFF); wr(DNL, 0); wr(CDNE, 4);
  endtask

  task automatic t_w1c;
    pulse(64'h0000_0002_0000_00F0, 0, 0);
    rchk("R6 ipl", IPL, 32'hF0);
    rchk("R6 iph", IPH, 32'h2);
    wr(IPL, 32'h30);
    rchk("R6 w1c partial", IPL, 32'hC0);
    wr(IPL, 0);
    rchk("R6 w1c zero", IPL, 32'hC0);
    wr(IPH, 32'hFFFF_FFFF);
    wr(IPL, 32'hFFFF_FFFF);
    rchk("R6 all ones lo", IPL, 0);
    rchk("R6 all ones hi", IPH, 0);
    chk("R8 irq clear", {31'd0, irq}, 0);
  endtask

  task automatic t_err;
    pulse(0, (64'd1 << 40) | 64'h20, 10'h2A5);
    rchk("R7 epl", EPL, 32'h20);
    rchk("R7 eph", EPH, 32'h100);
    rchk("R9 first error word", EST, 32'h8000_85A5);
    chk("R8 no irq without enable", {31'd0, irq}, 0);
    wr(SEIE, 40);
    chk("R8 irq with enable", {31'd0, irq}, 1);
    pulse(0, 64'h200, 10'h001);
    rchk("R9 first kept", EST, 32'h8000_85A5);
    rchk("R7 epl later", EPL, 32'h220);
    wr(CERR, 40);
    rchk("R10 pend cleared", EPH, 0);
    rchk("R10 other chan keeps status", EST, 32'h8000_85A5);
    chk("R8 irq drops", {31'd0, irq}, 0);
    wr(CERR, 5);
    rchk("R10 status cleared", EST, 0);
    rchk("R10 ch5 pend cleared", EPL, 32'h200);
    wr(EPL, 32'hFFFF_FFFF);
    rchk("R6 epend all ones", EPL, 0);
    pulse(0, 64'h400, 10'h100);
    rchk("R9 recapture", EST, 32'h8000_4A00);
    wr(CERR, 10); wr(CEIE, 40);
  endtask

  task automatic t_start;
    wr(SST, 45);
    chk("R11 pulse", {31'd0, start_pulse}, 1);
    chk("R11 chan", {26'd0, start_chan}, 45);
    chk("R12 dut16 no start ch45", {31'd0, start16}, 0);
    @(negedge clk);
    chk("R11 one cycle", {31'd0, start_pulse}, 0);
    wr(SST, 9);
    chk("R12 dut16 start ch9", {31'd0, start16}, 1);
    chk("R12 dut16 chan", {26'd0, schan16}, 9);
  endtask

  task automatic t_16;
    logic [31:0] v;
    wr(REQH, 32'hFFFF_FFFF);
    wr(REQL, 32'hFFFF_FFFF);
    @(negedge clk); bus_addr = REQH; #1 v = rdata16;
    chk("R12 hi word zero", v, 0);
    @(negedge clk); bus_addr = REQL; #1 v = rdata16;
    chk("R12 lo word 16 bits", v, 32'h0000_FFFF);
    wr(SEIE, 20);
    @(negedge clk); bus_addr = EIEL; #1 v = rdata16;
    chk("R12 cmd ch20 ignored", v, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_ctrl(); t_words(); t_cmds(); t_done();
    t_w1c(); t_err(); t_start(); t_16();
    summary();
  end
endmodule